// File: doc/BRIEF.md
# Lane-Parallel Vector Add Sequencer

This block adds two equal-length integer vectors, element by element, and writes the sums to a result store. All three stores sit next to the block and are split into banks, one bank per lane. The bank for lane k holds every element whose index gives remainder k when divided by the lane count. Each lane owns one read port per operand and one write port, so all lanes load, add and store in the same cycles.

One controller walks through the iterations. Each iteration spends 2 cycles fetching operands, 7 cycles in a pipelined adder model and 1 cycle writing back, for 10 cycles in all. Raising the lane count cuts the number of iterations to length/lanes, and each iteration still takes 10 cycles. Total latency therefore falls in proportion to the lane count, while the adder count grows by the same factor. A start pulse launches a run. A one-cycle done pulse ends it. A cycle counter reports the latency the run took.

Top module: `vadd_lanes_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, done, rd_en and wr_en are 0 and cycle_cnt is 0.
- R2: A start sampled while idle raises busy at the next edge. Busy then stays high, with no gap, until the final write-back cycle has ended.
- R3: Each iteration takes 10 cycles. rd_en is high only in its first cycle and wr_en only in its tenth cycle. Both are 1-cycle strobes and are never high together.
- R4: In iteration j, rd_idx and wr_idx both equal j. The operand and result words of lane k sit at bits [k*DW +: DW] of the lane buses, and they carry element j*LANES+k.
- R5: Each stored sum is the two operands added modulo 2^DW, with carries discarded.
- R6: A run makes exactly LEN/LANES iterations, with indices ascending from 0. Each bank word is written exactly once.
- R7: done is high for exactly one cycle, the first cycle after the final write-back. In that cycle busy is low.
- R8: cycle_cnt is cleared by the start that opens a run. At run end it equals (LEN/LANES)*10, and it holds that value until the next accepted start.
- R9: A start asserted while busy is ignored. The run's timing, count and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cycle_cnt | output | CW | Cycles spent by the current or last run |
| rd_en | output | 1 | Read strobe to all operand banks |
| rd_idx | output | IW | Bank word address for reads |
| a_rdata | input | LANES*DW | First operand word of every lane, returned one cycle after rd_en |
| b_rdata | input | LANES*DW | Second operand word of every lane, returned one cycle after rd_en |
| wr_en | output | 1 | Write strobe to all result banks |
| wr_idx | output | IW | Bank word address for writes |
| wr_data | output | LANES*DW | Sum word of every lane |

## Verification
The bound checker watches on every cycle that:
- the read and write strobes last one cycle and never overlap;
- done is a lone pulse that follows a write-back;
- busy never drops except into done;
- cycle_cnt stays frozen while the block is idle.

Three things only the bench scenarios can show: that each write lands at the right cycle offset and address, that the stored sums match the arithmetic for each lane's element, and that a start raised in mid-run leaves both the count and the results untouched. The scenarios include patterns that wrap past the top of the word.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_ADD   = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;
endpackage

// File: rtl/vadd_seq.sv
module vadd_seq
  import vadd_pkg::*;
#(
  parameter int ITERS   = 256,
  parameter int IW      = 8,
  parameter int CW      = 12,
  parameter int RD_CYC  = 2,
  parameter int ADD_CYC = 7,
  parameter int WR_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          rd_en,
  output logic          cap,
  output logic          adv,
  output logic          wr_en,
  output logic [IW-1:0] iter,
  output logic [CW-1:0] cycle_cnt
);
  localparam int SW = $clog2(RD_CYC + ADD_CYC + WR_CYC + 1);

  phase_e        ph_q, ph_d;
  logic [SW-1:0] step_q, step_d;
  logic [IW-1:0] iter_q, iter_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          last_rd, last_add, last_wr, last_iter;

  assign last_rd   = (step_q == SW'(RD_CYC - 1));
  assign last_add  = (step_q == SW'(ADD_CYC - 1));
  assign last_wr   = (step_q == SW'(WR_CYC - 1));
  assign last_iter = (iter_q == IW'(ITERS - 1));

  always_comb begin
    ph_d   = ph_q;
    step_d = step_q + SW'(1);
    iter_d = iter_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (ph_q != PH_IDLE) cnt_d = cnt_q + CW'(1);
    unique case (ph_q)
      PH_IDLE: begin
        step_d = '0;
        if (start) begin
          ph_d   = PH_READ;
          iter_d = '0;
          cnt_d  = '0;
        end
      end
      PH_READ: if (last_rd) begin
        ph_d   = PH_ADD;
        step_d = '0;
      end
      PH_ADD: if (last_add) begin
        ph_d   = PH_WRITE;
        step_d = '0;
      end
      PH_WRITE: if (last_wr) begin
        step_d = '0;
        if (last_iter) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          ph_d   = PH_READ;
          iter_d = iter_q + IW'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      step_q <= '0;
      iter_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      step_q <= step_d;
      iter_q <= iter_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign done      = done_q;
  assign rd_en     = (ph_q == PH_READ) && (step_q == '0);
  assign cap       = (ph_q == PH_READ) && last_rd;
  assign adv       = (ph_q == PH_ADD);
  assign wr_en     = (ph_q == PH_WRITE) && last_wr;
  assign iter      = iter_q;
  assign cycle_cnt = cnt_q;
endmodule

// File: rtl/vadd_lane.sv
module vadd_lane #(
  parameter int DW      = 32,
  parameter int ADD_CYC = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          adv,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  output logic [DW-1:0] sum_out
);
  logic [DW-1:0] op_a_q, op_b_q;
  logic [DW-1:0] pipe_q [ADD_CYC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_a_q <= '0;
      op_b_q <= '0;
    end else if (cap) begin
      op_a_q <= a_in;
      op_b_q <= b_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= '0;
    else if (adv) pipe_q[0] <= op_a_q + op_b_q;
  end

  for (genvar s = 1; s < ADD_CYC; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[s] <= '0;
      else if (adv) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign sum_out = pipe_q[ADD_CYC-1];
endmodule

// File: rtl/vadd_lanes_top.sv
module vadd_lanes_top #(
  parameter int LEN     = 1024,
  parameter int LANES   = 4,
  parameter int DW      = 32,
  parameter int RD_CYC  = 2,
  parameter int ADD_CYC = 7,
  parameter int WR_CYC  = 1,
  localparam int ITERS  = LEN / LANES,
  localparam int IW     = (ITERS > 1) ? $clog2(ITERS) : 1,
  localparam int CW     = $clog2(ITERS * (RD_CYC + ADD_CYC + WR_CYC) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic [CW-1:0]       cycle_cnt,
  output logic                rd_en,
  output logic [IW-1:0]       rd_idx,
  input  logic [LANES*DW-1:0] a_rdata,
  input  logic [LANES*DW-1:0] b_rdata,
  output logic                wr_en,
  output logic [IW-1:0]       wr_idx,
  output logic [LANES*DW-1:0] wr_data
);
  if (LANES < 1 || LANES > LEN || (LEN % LANES) != 0) begin : g_bad_cfg
    $error("vadd_lanes_top: LEN must be a multiple of LANES, 1 <= LANES <= LEN");
  end

  logic          cap, adv;
  logic [IW-1:0] iter;

  vadd_seq #(
    .ITERS(ITERS), .IW(IW), .CW(CW),
    .RD_CYC(RD_CYC), .ADD_CYC(ADD_CYC), .WR_CYC(WR_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .rd_en(rd_en), .cap(cap), .adv(adv),
    .wr_en(wr_en), .iter(iter), .cycle_cnt(cycle_cnt)
  );

  assign rd_idx = iter;
  assign wr_idx = iter;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vadd_lane #(.DW(DW), .ADD_CYC(ADD_CYC)) u_lane (
      .clk(clk), .rst_n(rst_n), .cap(cap), .adv(adv),
      .a_in(a_rdata[k*DW +: DW]),
      .b_in(b_rdata[k*DW +: DW]),
      .sum_out(wr_data[k*DW +: DW])
    );
  end
endmodule

// File: rtl/vadd_chk.sv
module vadd_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rd_en,
  input logic          wr_en,
  input logic [CW-1:0] cycle_cnt
);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && !busy));
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  // R8
  cnt_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cycle_cnt));
endmodule

bind vadd_lanes_top vadd_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_en(rd_en), .wr_en(wr_en), .cycle_cnt(cycle_cnt)
);

// File: tb/vadd_lanes_top_tb_top.sv
module vadd_lanes_top_tb_top;
  localparam int PER   = 10;
  localparam int LEN   = 16;
  localparam int LANES = 4;
  localparam int DW    = 32;
  localparam int ITERS = LEN / LANES;
  localparam int IW    = $clog2(ITERS);
  localparam int CW    = $clog2(ITERS * 10 + 1);

  logic                clk, rst_n, start;
  logic                busy, done, rd_en, wr_en;
  logic [CW-1:0]       cycle_cnt;
  logic [IW-1:0]       rd_idx, wr_idx;
  logic [LANES*DW-1:0] a_rdata, b_rdata, wr_data;

  logic [DW-1:0] mem_a [LEN];
  logic [DW-1:0] mem_b [LEN];
  logic [DW-1:0] mem_r [LEN];
  int            wr_hits [LEN];

  int total, bad;
  bit finished;

  vadd_lanes_top #(.LEN(LEN), .LANES(LANES), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cycle_cnt(cycle_cnt), .rd_en(rd_en), .rd_idx(rd_idx),
    .a_rdata(a_rdata), .b_rdata(b_rdata), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #(PER/2) clk = ~clk;

  // banked memory model: bank k word j = element j*LANES+k
  always @(posedge clk) begin
    if (rd_en)
      for (int k = 0; k < LANES; k++) begin
        a_rdata[k*DW +: DW] <= mem_a[int'(rd_idx)*LANES + k];
        b_rdata[k*DW +: DW] <= mem_b[int'(rd_idx)*LANES + k];
      end
    if (wr_en)
      for (int k = 0; k < LANES; k++) begin
        mem_r[int'(wr_idx)*LANES + k] <= wr_data[k*DW +: DW];
        wr_hits[int'(wr_idx)*LANES + k] <= wr_hits[int'(wr_idx)*LANES + k] + 1;
      end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int pat, input bit late_start);
    int t, seq_err;
    for (int e = 0; e < LEN; e++) begin
      case (pat)
        0: begin mem_a[e] = '0; mem_b[e] = '0; end
        1: begin mem_a[e] = DW'(e); mem_b[e] = DW'(1000 * e + 7); end
        2: begin mem_a[e] = '1; mem_b[e] = DW'(e + 1); end
        3: begin mem_a[e] = DW'(32'h9E3779B9 * (e + 3)); mem_b[e] = DW'(32'h85EBCA6B ^ (e << 9)); end
        default: begin mem_a[e] = DW'(e) << 27; mem_b[e] = 32'hF000_0000 + DW'(e); end
      endcase
      mem_r[e] = 32'hDEAD_BEEF;
      wr_hits[e] = 0;
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 busy rises, R8 count cleared at start
    check(busy == 1'b1, "R2", busy, 1);
    check(cycle_cnt == '0, "R8", cycle_cnt, 0);
    t = 0;
    seq_err = 0;
    while (busy && t < 1000) begin
      if (late_start) start = (t == 15);  // R9 start during a run
      if (rd_en && !((t % 10) == 0 && int'(rd_idx) == t / 10)) seq_err++;
      if (!rd_en && (t % 10) == 0) seq_err++;
      if (wr_en && !((t % 10) == 9 && int'(wr_idx) == t / 10)) seq_err++;
      if (!wr_en && (t % 10) == 9) seq_err++;
      if (done) seq_err++;
      t++;
      @(negedge clk);
    end
    start = 1'b0;
    // R3 R4 strobe timing and indices
    check(seq_err == 0, "R3/R4 strobe timing", seq_err, 0);
    // R6 R9 trip count and busy length
    check(t == ITERS * 10, "R6 busy cycles", t, ITERS * 10);
    // R7 done pulse right after last write-back
    check(done == 1'b1 && busy == 1'b0, "R7 done", done, 1);
    // R8 reported latency
    check(int'(cycle_cnt) == ITERS * 10, "R8 cycle_cnt", cycle_cnt, ITERS * 10);
    for (int e = 0; e < LEN; e++) begin
      // R5 modular sum, R4 lane/element mapping
      check(mem_r[e] == DW'(mem_a[e] + mem_b[e]), "R5 sum", mem_r[e], DW'(mem_a[e] + mem_b[e]));
      // R6 each word written once
      check(wr_hits[e] == 1, "R6 writes", wr_hits[e], 1);
    end
    @(negedge clk);
    check(done == 1'b0, "R7 done width", done, 0);
    // R8 count held while idle
    check(int'(cycle_cnt) == ITERS * 10, "R8 hold", cycle_cnt, ITERS * 10);
  endtask

  initial begin
    total = 0;
    bad = 0;
    finished = 1'b0;
    start = 1'b0;
    rst_n = 1'b0;
    a_rdata = '0;
    b_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, rd_en, wr_en} == 4'b0 && cycle_cnt == '0, "R1 in reset",
          {busy, done, rd_en, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, rd_en, wr_en} == 4'b0 && cycle_cnt == '0, "R1 after reset",
          {busy, done, rd_en, wr_en}, 0);
    for (int p = 0; p < 5; p++) run(p, p == 3);
    run(1, 1'b1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PER * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule